// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Cache

This block caches address translations so that most loads and stores avoid a page table lookup. Each of its entries maps one page of a process's virtual space to a physical page. A lookup presents a process identifier and a virtual address. In the same cycle, the block compares that pair against every stored entry at once. On a hit it returns the physical address, formed from the stored physical page number followed by the untranslated offset within the page.

Entries carry the identifier of the process that owns them, so translations from several processes live side by side. A context switch therefore needs no invalidation. After a miss, a walker outside this block installs the translation through the fill port. The flush command clears either the whole table or only the entries of one identifier. Software uses the flush when it hands an identifier to a new process.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, so no lookup hits until a fill has been made.
- R2: A lookup is combinational. When some valid entry matches, lk_hit is 1 and lk_pa is that entry's physical page number in bits [PA_W-1:OFF_W], with lk_va[OFF_W-1:0] passed through unchanged in bits [OFF_W-1:0]. OFF_W defaults to 12, which gives 4 KB pages.
- R3: A hit requires both the process identifier and the virtual page number lk_va[VA_W-1:OFF_W] to match. The same virtual page under two identifiers can hold two different physical pages, and each lookup returns its own.
- R4: The table holds ENTRIES translations (32 by default), and all of them can be valid and hit at the same time.
- R5: When no valid entry already matches the new translation, a fill goes to the lowest-indexed invalid entry if one exists, and the replacement pointer does not move.
- R6: When the table is full, a fill of a new translation overwrites the entry at the round-robin pointer. The pointer is 0 after reset, advances by one after each such eviction, and wraps from ENTRIES-1 to 0.
- R7: A fill whose identifier and page match a valid entry overwrites that entry in place, so no duplicate entry is created, and the pointer does not move.
- R8: A flush with flush_all=1 invalidates every entry. A flush with flush_all=0 invalidates only the entries whose identifier equals flush_pid.
- R9: A fill presented in the same cycle as a flush has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pid | input | PID_W | Process identifier of the lookup |
| lk_va | input | VA_W | Virtual address of the lookup |
| lk_hit | output | 1 | A valid entry matches the lookup |
| lk_pa | output | PA_W | Translated physical address, meaningful when lk_hit is 1 |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_pid | input | PID_W | Process identifier of the new translation |
| fill_vpn | input | VA_W-OFF_W | Virtual page number of the new translation |
| fill_ppn | input | PA_W-OFF_W | Physical page number of the new translation |
| flush_en | input | 1 | Invalidate entries at the next edge |
| flush_all | input | 1 | 1 clears all entries; 0 clears only entries of flush_pid |
| flush_pid | input | PID_W | Process identifier to clear when flush_all is 0 |

## Verification
The bench first fills every entry under one identifier and then sweeps all pages with a different page offset for each. This shows that every slot stores its own page, and that the offset reaches the output. The same pages are then looked up under another identifier, which must miss, so a match on the page alone is not enough for a hit. A crafted sequence then reaches each fill case in turn: a duplicate fill, an eviction from a full table, and a fill into a freed slot. The outcome of each case shows which entry was overwritten, so a pointer that advances at the wrong time or a victim chosen in the wrong order leaves a different page missing. Flushes by identifier and of the whole table, one of them with a fill in the same cycle, complete the set.

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 32,
  parameter int PID_W   = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PID_W-1:0]      lk_pid,
  input  logic [VA_W-1:0]       lk_va,
  output logic                  lk_hit,
  output logic [PA_W-1:0]       lk_pa,
  input  logic                  fill_en,
  input  logic [PID_W-1:0]      fill_pid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  flush_en,
  input  logic                  flush_all,
  input  logic [PID_W-1:0]      flush_pid
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PID_W-1:0] t_pid [ENTRIES];
  logic [VPN_W-1:0] t_vpn [ENTRIES];
  logic [PPN_W-1:0] t_ppn [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [IDX_W-1:0] ptr;

  logic [PPN_W-1:0] hit_ppn;
  logic             dup, free;
  logic [IDX_W-1:0] dup_idx, free_idx, tgt;

  always_comb begin
    lk_hit  = 1'b0;
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (vld[i] && t_pid[i] == lk_pid && t_vpn[i] == lk_va[VA_W-1:OFF_W]) begin
        lk_hit  = 1'b1;
        hit_ppn = hit_ppn | t_ppn[i];
      end
  end

  assign lk_pa = {hit_ppn, lk_va[OFF_W-1:0]};

  always_comb begin
    dup = 1'b0; dup_idx = '0;
    free = 1'b0; free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld[i] && t_pid[i] == fill_pid && t_vpn[i] == fill_vpn) begin
        dup = 1'b1; dup_idx = IDX_W'(i);
      end
      if (!vld[i]) begin
        free = 1'b1; free_idx = IDX_W'(i);
      end
    end
  end

  assign tgt = dup ? dup_idx : (free ? free_idx : ptr);

  wire do_fill = fill_en && !flush_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush_en) begin
      for (int i = 0; i < ENTRIES; i++)
        if (flush_all || t_pid[i] == flush_pid) vld[i] <= 1'b0;
    end else if (do_fill) begin
      vld[tgt] <= 1'b1;
      if (!dup && !free)
        ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end

  always_ff @(posedge clk)
    if (do_fill) begin
      t_pid[tgt] <= fill_pid;
      t_vpn[tgt] <= fill_vpn;
      t_ppn[tgt] <= fill_ppn;
    end
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int PID_W = 8,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [PID_W-1:0]      lk_pid,
  input logic [VA_W-1:0]       lk_va,
  input logic                  lk_hit,
  input logic [PA_W-1:0]       lk_pa,
  input logic                  fill_en,
  input logic [PID_W-1:0]      fill_pid,
  input logic [VA_W-OFF_W-1:0] fill_vpn,
  input logic [PA_W-OFF_W-1:0] fill_ppn,
  input logic                  flush_en,
  input logic                  flush_all,
  input logic [PID_W-1:0]      flush_pid
);
  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]);

  // R5 R6 R7: a completed fill is visible to a lookup of the same pair
  assert_fill_then_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_en) |=>
      ((lk_pid == $past(fill_pid) && lk_va[VA_W-1:OFF_W] == $past(fill_vpn)) ->
        (lk_hit && lk_pa[PA_W-1:OFF_W] == $past(fill_ppn))));

  assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && flush_all) |=> !lk_hit);

  assert_flush_pid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !flush_all) |=> ((lk_pid == $past(flush_pid)) -> !lk_hit));

  assert_flush_blocks_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && fill_en && flush_pid == fill_pid) |=>
      ((lk_pid == $past(fill_pid) && lk_va[VA_W-1:OFF_W] == $past(fill_vpn)) -> !lk_hit));
endmodule

bind xlat_cache xlat_cache_chk #(.PID_W(PID_W), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int N = 32, PID_W = 8, VA_W = 32, PA_W = 32, OFF_W = 12;

  logic clk = 0, rst_n = 0;
  logic [PID_W-1:0] lk_pid = '0, fill_pid = '0, flush_pid = '0;
  logic [VA_W-1:0] lk_va = '0;
  logic lk_hit;
  logic [PA_W-1:0] lk_pa;
  logic fill_en = 0, flush_en = 0, flush_all = 0;
  logic [VA_W-OFF_W-1:0] fill_vpn = '0;
  logic [PA_W-OFF_W-1:0] fill_ppn = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xlat_cache u0 (.*);

  task automatic fill(input int pid, input int vpn, input int ppn);
    @(negedge clk);
    fill_en = 1; fill_pid = PID_W'(pid); fill_vpn = (VA_W-OFF_W)'(vpn); fill_ppn = (PA_W-OFF_W)'(ppn);
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic flush(input bit all, input int pid);
    @(negedge clk);
    flush_en = 1; flush_all = all; flush_pid = PID_W'(pid);
    @(negedge clk);
    flush_en = 0; flush_all = 0;
  endtask

  task automatic look(input string req, input int pid, input int vpn, input int off,
                      input bit ehit, input int eppn);
    logic [PA_W-1:0] epa;
    @(negedge clk);
    lk_pid = PID_W'(pid);
    lk_va = {(VA_W-OFF_W)'(vpn), OFF_W'(off)};
    #1;
    epa = {(PA_W-OFF_W)'(eppn), OFF_W'(off)};
    total++;
    if (lk_hit !== ehit || (ehit && lk_pa !== epa)) begin
      bad++;
      $display("FAIL %s pid=%0d vpn=%0d: hit=%0b pa=%h expected hit=%0b pa=%h",
               req, pid, vpn, lk_hit, lk_pa, ehit, epa);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    look("R1", 0, 0, 0, 0, 0);
    look("R1", 0, 8, 5, 0, 0);
    for (int i = 0; i < N; i++) fill(0, i, 100 + i);
    for (int i = 0; i < N; i++) look("R4 R2", 0, i, (i * 37 + 1) % 4096, 1, 100 + i);
    for (int i = 0; i < N; i++) look("R3", 1, i, 3, 0, 0);
    // full table: evicts entry 0 (pid0 vpn0), pointer -> 1
    fill(1, 8, 44);
    look("R6", 1, 8, 7, 1, 44);
    look("R3", 0, 8, 7, 1, 108);
    look("R6", 0, 0, 0, 0, 0);
    // duplicate refill of entry 5, pointer unchanged
    fill(0, 5, 999);
    look("R7", 0, 5, 12, 1, 999);
    // evicts entry 1, not 2
    fill(2, 70, 70);
    look("R7 R6", 0, 1, 0, 0, 0);
    look("R7 R6", 0, 2, 0, 1, 102);
    look("R6", 2, 70, 4095, 1, 70);
    flush(0, 1);
    look("R8", 1, 8, 0, 0, 0);
    look("R8", 0, 8, 0, 1, 108);
    look("R8", 2, 70, 0, 1, 70);
    // entry 0 free: fill goes there, pointer stays at 2
    fill(3, 9, 9);
    look("R5", 3, 9, 1, 1, 9);
    look("R5", 0, 3, 1, 1, 103);
    fill(3, 10, 10);
    look("R5 R6", 0, 2, 0, 0, 0);
    look("R5 R6", 0, 3, 0, 1, 103);
    look("R5", 3, 9, 0, 1, 9);
    look("R6", 3, 10, 0, 1, 10);
    // flush all with a simultaneous fill
    @(negedge clk);
    flush_en = 1; flush_all = 1; fill_en = 1; fill_pid = 4; fill_vpn = 20; fill_ppn = 20;
    @(negedge clk);
    flush_en = 0; flush_all = 0; fill_en = 0;
    look("R9", 4, 20, 0, 0, 0);
    look("R8", 0, 20, 0, 0, 0);
    look("R8", 3, 10, 0, 0, 0);
    fill(0, 3, 333);
    look("R5", 0, 3, 9, 1, 333);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule